// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a core's store path and the next cache level. It holds a small set of line-sized gathering buffers. Each buffer tracks one line address and merges incoming word stores into it under their byte enables. The downstream cache therefore receives whole-line writes instead of a stream of small stores. When all bytes of a line are written, the buffer sends the line downstream and becomes free. A store to a new line that finds no free buffer forces the least recently used buffer out early, as a partial write that carries its byte-valid mask.

The buffers can serve two hardware threads in one of two ways. They can form a single shared pool, or each thread can be confined to one fixed half, and the halves stay split even when only one thread is running. A build-time setting can keep a minimum number of buffers empty by draining the least recently used one ahead of need. A flush command drains every open buffer and reports completion with a one-cycle pulse.

Top module: `wc_store_buf`

## Requirements
- R1: During and after reset, with no stimulus, `st_ready_o` is 1 and `lw_valid_o` and `flush_done_o` are 0.
- R2: A store carries a word address: its low log2(LINE_BYTES/WORD_BYTES) bits select the word in the line and the rest is the line address. Byte lane j of `st_data_i` maps to line byte WORD_BYTES*word+j. Line byte k appears at `lw_data_o[8k+7:8k]` with valid flag `lw_mask_o[k]`. Stores to an open line merge, and a later store overwrites earlier bytes at the same offset. Bytes that no store wrote come out as zero.
- R3: Once every byte of a buffered line is valid, the line is sent downstream with an all-ones mask without any further command, and its buffer becomes free.
- R4: A store to a line with no open buffer and no free buffer in its pool evicts that pool's least recently used buffer as a partial line. Recency is refreshed on every store hit and every allocation. The new line takes the evicted buffer.
- R5: When an eviction is needed and the output still holds a line that has not been accepted, `st_ready_o` stays 0 until the output can take the victim. In that case the store is accepted in the same cycle that the output frees up.
- R6: While `lw_valid_o` is 1 and `lw_ready_i` is 0, the line-write outputs hold their values.
- R7: On `flush_i`, stores are refused from the next cycle on. Valid buffers drain lowest index first. `flush_done_o` pulses for one cycle once no buffer is valid and the output is empty.
- R8: With `part_mode_i`=0, stores from either thread use any of the NUM_BUF buffers, so NUM_BUF distinct lines are held without an eviction.
- R9: With `part_mode_i`=1, thread 0 uses buffers below NUM_BUF/2 and thread 1 uses the rest. A lone thread therefore evicts on its (NUM_BUF/2+1)-th distinct line.
- R10: With KEEP_FREE>0, whenever fewer than KEEP_FREE buffers are free and no flush or full-line send is pending, the least recently used valid buffer is sent early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| part_mode_i | input | 1 | 0: shared pool, 1: fixed halves per thread |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store accepted this cycle when high with valid |
| st_addr_i | input | ADDR_W | Word address of the store |
| st_data_i | input | WORD_BYTES*8 | Store data |
| st_be_i | input | WORD_BYTES | Store byte enables |
| st_tid_i | input | 1 | Hardware thread of the store |
| flush_i | input | 1 | Drain all buffers |
| flush_done_o | output | 1 | One-cycle pulse when a drain completes |
| lw_valid_o | output | 1 | Line write valid |
| lw_ready_i | input | 1 | Downstream accepts the line write |
| lw_addr_o | output | ADDR_W-log2(LINE_BYTES/WORD_BYTES) | Line address |
| lw_data_o | output | LINE_BYTES*8 | Line data |
| lw_mask_o | output | LINE_BYTES | Per-byte valid mask |

## Verification
A store accepted at edge N is in its buffer after N. If that store completes the line, the line is loaded into the output register at edge N+1 when the output is free. A victim evicted by a store is loaded at edge N itself. A flush is seen from the edge that samples `flush_i`, so `st_ready_o` is already low at the following negative edge, and the done pulse lasts exactly one cycle. The bench drives inputs 2 ns after a rising edge and samples at falling edges. A scoreboard compares line writes in arrival order, not at a fixed cycle. The stall, hold, idle and pulse checks each sample the single falling edge at which their result is due.

// File: rtl/wc_pkg.sv
package wc_pkg;
  // source of the line moved into the output register this cycle
  typedef enum logic [2:0] {
    MV_NONE,
    MV_EVICT,
    MV_DRAIN,
    MV_FULL,
    MV_SPARE
  } mv_src_e;
endpackage

// File: rtl/wc_line_slot.sv
module wc_line_slot #(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int LA_W       = 26,
  localparam int WIDX_W    = $clog2(LINE_BYTES / WORD_BYTES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  logic                      merge_i,
  input  logic                      release_i,
  input  logic [LA_W-1:0]           line_i,
  input  logic [WIDX_W-1:0]         widx_i,
  input  logic [WORD_BYTES*8-1:0]   data_i,
  input  logic [WORD_BYTES-1:0]     be_i,
  output logic                      valid_o,
  output logic                      hit_o,
  output logic                      full_o,
  output logic [LA_W-1:0]           line_o,
  output logic [LINE_BYTES*8-1:0]   data_o,
  output logic [LINE_BYTES-1:0]     mask_o
);
  logic                    valid_q;
  logic [LA_W-1:0]         line_q;
  logic [LINE_BYTES-1:0]   mask_q;
  logic [LINE_BYTES*8-1:0] data_q;
  logic [LINE_BYTES-1:0]   wr_sel;
  logic [LINE_BYTES*8-1:0] wr_data;

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      wr_sel[b] = (widx_i == WIDX_W'(b / WORD_BYTES)) && be_i[b % WORD_BYTES];
      wr_data[b*8 +: 8] = data_i[(b % WORD_BYTES)*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      mask_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      line_q  <= line_i;
      mask_q  <= wr_sel;
    end else if (merge_i) begin
      mask_q  <= mask_q | wr_sel;
    end else if (release_i) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end
  end

  // unwritten bytes of a fresh line read as zero
  always_ff @(posedge clk_i) begin
    if (alloc_i || merge_i) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (wr_sel[b])    data_q[b*8 +: 8] <= wr_data[b*8 +: 8];
        else if (alloc_i) data_q[b*8 +: 8] <= 8'h00;
      end
    end
  end

  assign valid_o = valid_q;
  assign hit_o   = valid_q && (line_q == line_i);
  assign full_o  = &mask_q;
  assign line_o  = line_q;
  assign data_o  = data_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/wc_age_rank.sv
module wc_age_rank #(
  parameter int NUM = 10,
  localparam int IW = $clog2(NUM)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           touch_i,
  input  logic [IW-1:0]  touch_idx_i,
  input  logic [NUM-1:0] cand_i,
  output logic [IW-1:0]  pick_o,
  output logic           pick_ok_o
);
  // rank 0 is oldest, NUM-1 newest; ranks stay a permutation
  logic [IW-1:0] rank_q [NUM];
  logic [IW-1:0] best;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) rank_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NUM; i++) begin
        if (IW'(i) == touch_idx_i)              rank_q[i] <= IW'(NUM - 1);
        else if (rank_q[i] > rank_q[touch_idx_i]) rank_q[i] <= rank_q[i] - 1'b1;
      end
    end
  end

  always_comb begin
    pick_o    = '0;
    pick_ok_o = 1'b0;
    best      = '1;
    for (int i = 0; i < NUM; i++) begin
      if (cand_i[i] && (!pick_ok_o || rank_q[i] < best)) begin
        pick_o    = IW'(i);
        best      = rank_q[i];
        pick_ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wc_store_buf.sv
module wc_store_buf
  import wc_pkg::*;
#(
  parameter int NUM_BUF    = 10,
  parameter int ADDR_W     = 29,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int KEEP_FREE  = 0,
  localparam int WIDX_W    = $clog2(LINE_BYTES / WORD_BYTES),
  localparam int LA_W      = ADDR_W - WIDX_W,
  localparam int LBITS     = LINE_BYTES * 8,
  localparam int WBITS     = WORD_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              part_mode_i,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [WBITS-1:0]  st_data_i,
  input  logic [WORD_BYTES-1:0] st_be_i,
  input  logic              st_tid_i,
  input  logic              flush_i,
  output logic              flush_done_o,
  output logic              lw_valid_o,
  input  logic              lw_ready_i,
  output logic [LA_W-1:0]   lw_addr_o,
  output logic [LBITS-1:0]  lw_data_o,
  output logic [LINE_BYTES-1:0] lw_mask_o
);
  localparam int IW   = $clog2(NUM_BUF);
  localparam int HALF = NUM_BUF / 2;

  function automatic logic [IW-1:0] low_idx(input logic [NUM_BUF-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [LA_W-1:0]   st_line;
  logic [WIDX_W-1:0] st_widx;
  assign st_line = st_addr_i[ADDR_W-1:WIDX_W];
  assign st_widx = st_addr_i[WIDX_W-1:0];

  logic [NUM_BUF-1:0]    s_valid, s_hit, s_full, pool;
  logic [NUM_BUF-1:0]    alloc_v, merge_v, rel_v;
  logic [LA_W-1:0]       s_line [NUM_BUF];
  logic [LBITS-1:0]      s_data [NUM_BUF];
  logic [LINE_BYTES-1:0] s_mask [NUM_BUF];

  logic [NUM_BUF-1:0] hit_vec, free_vec, hit_fire, full_cand, age_cand;
  logic               hit_any, free_any, valid_any, full_any;
  logic [IW-1:0]      hit_idx, free_idx, alloc_idx, touch_idx, victim, mv_idx;
  logic               victim_ok, out_can_load, evict_need, st_fire, mv_go;
  logic               busy_q, done;
  mv_src_e            mv_src;

  logic                  lw_valid_q;
  logic [LA_W-1:0]       lw_addr_q;
  logic [LBITS-1:0]      lw_data_q;
  logic [LINE_BYTES-1:0] lw_mask_q;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    assign pool[g]    = !part_mode_i || (st_tid_i ? (g >= HALF) : (g < HALF));
    assign alloc_v[g] = st_fire && !hit_any && (alloc_idx == IW'(g));
    assign merge_v[g] = st_fire && hit_any && (hit_idx == IW'(g));
    assign rel_v[g]   = mv_go && (mv_idx == IW'(g));

    wc_line_slot #(
      .LINE_BYTES(LINE_BYTES),
      .WORD_BYTES(WORD_BYTES),
      .LA_W      (LA_W)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (alloc_v[g]),
      .merge_i  (merge_v[g]),
      .release_i(rel_v[g]),
      .line_i   (st_line),
      .widx_i   (st_widx),
      .data_i   (st_data_i),
      .be_i     (st_be_i),
      .valid_o  (s_valid[g]),
      .hit_o    (s_hit[g]),
      .full_o   (s_full[g]),
      .line_o   (s_line[g]),
      .data_o   (s_data[g]),
      .mask_o   (s_mask[g])
    );
  end

  // lookup and allocation within the thread's pool
  assign hit_vec   = s_hit & pool;
  assign free_vec  = ~s_valid & pool;
  assign hit_any   = |hit_vec;
  assign free_any  = |free_vec;
  assign valid_any = |s_valid;
  assign hit_idx   = low_idx(hit_vec);
  assign free_idx  = low_idx(free_vec);
  assign alloc_idx = free_any ? free_idx : victim;
  assign touch_idx = hit_any ? hit_idx : alloc_idx;

  assign out_can_load = !lw_valid_q || lw_ready_i;
  assign evict_need   = st_valid_i && !busy_q && !hit_any && !free_any;
  assign st_ready_o   = !busy_q && (hit_any || free_any || out_can_load);
  assign st_fire      = st_valid_i && st_ready_o;
  assign hit_fire     = st_fire ? hit_vec : '0;
  assign full_cand    = s_full & s_valid & ~hit_fire;
  assign full_any     = |full_cand;
  assign age_cand     = evict_need ? (s_valid & pool) : (s_valid & ~hit_fire);

  wc_age_rank #(.NUM(NUM_BUF)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (st_fire),
    .touch_idx_i(touch_idx),
    .cand_i     (age_cand),
    .pick_o     (victim),
    .pick_ok_o  (victim_ok)
  );

  // one line may enter the output register per cycle
  always_comb begin
    mv_src = MV_NONE;
    mv_idx = '0;
    if (evict_need && out_can_load) begin
      mv_src = MV_EVICT;
      mv_idx = victim;
    end else if (busy_q && valid_any) begin
      mv_src = MV_DRAIN;
      mv_idx = low_idx(s_valid);
    end else if (full_any) begin
      mv_src = MV_FULL;
      mv_idx = low_idx(full_cand);
    end else if (KEEP_FREE > 0 && $countones(~s_valid) < KEEP_FREE && victim_ok) begin
      mv_src = MV_SPARE;
      mv_idx = victim;
    end
  end
  assign mv_go = (mv_src != MV_NONE) && out_can_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lw_valid_q <= 1'b0;
      lw_addr_q  <= '0;
      lw_mask_q  <= '0;
    end else if (mv_go) begin
      lw_valid_q <= 1'b1;
      lw_addr_q  <= s_line[mv_idx];
      lw_mask_q  <= s_mask[mv_idx];
    end else if (lw_ready_i) begin
      lw_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (mv_go) lw_data_q <= s_data[mv_idx];
  end

  assign done = busy_q && !valid_any && !lw_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (flush_i) busy_q <= 1'b1;
    else if (done)    busy_q <= 1'b0;
  end

  assign flush_done_o = done;
  assign lw_valid_o   = lw_valid_q;
  assign lw_addr_o    = lw_addr_q;
  assign lw_data_o    = lw_data_q;
  assign lw_mask_o    = lw_mask_q;
endmodule

// File: rtl/wc_store_buf_chk.sv
module wc_store_buf_chk #(
  parameter int LA_W       = 26,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    st_valid_i,
  input logic                    st_ready_o,
  input logic                    flush_i,
  input logic                    flush_done_o,
  input logic                    lw_valid_o,
  input logic                    lw_ready_i,
  input logic [LA_W-1:0]         lw_addr_o,
  input logic [LINE_BYTES*8-1:0] lw_data_o,
  input logic [LINE_BYTES-1:0]   lw_mask_o,
  input logic                    busy_i
);
  // R6
  lw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_valid_o && !lw_ready_i |=> lw_valid_o && $stable(lw_addr_o)
      && $stable(lw_data_o) && $stable(lw_mask_o));

  // R5
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && !st_ready_o |-> busy_i || (lw_valid_o && !lw_ready_i));

  // R7
  flush_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !st_ready_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o && !flush_i |=> !flush_done_o);
endmodule

bind wc_store_buf wc_store_buf_chk #(
  .LA_W      (LA_W),
  .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_valid_i  (st_valid_i),
  .st_ready_o  (st_ready_o),
  .flush_i     (flush_i),
  .flush_done_o(flush_done_o),
  .lw_valid_o  (lw_valid_o),
  .lw_ready_i  (lw_ready_i),
  .lw_addr_o   (lw_addr_o),
  .lw_data_o   (lw_data_o),
  .lw_mask_o   (lw_mask_o),
  .busy_i      (busy_q)
);

// File: tb/tb_wc_store_buf.sv
module tb_wc_store_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // main instance: 10 buffers; spare instance: 8 buffers, 2 kept free
  logic         part_mode = 0, st_valid = 0, st_tid = 0, flush = 0, lw_ready = 1;
  logic [28:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic [7:0]   st_be = '0;
  logic         st_ready, done, lw_valid;
  logic [25:0]  lw_addr;
  logic [511:0] lw_data;
  logic [63:0]  lw_mask;

  logic         k_st_valid = 0, k_flush = 0, k_lw_ready = 1;
  logic [28:0]  k_st_addr = '0;
  logic [63:0]  k_st_data = '0;
  logic [7:0]   k_st_be = '0;
  logic         k_st_ready, k_done, k_lw_valid;
  logic [25:0]  k_lw_addr;
  logic [511:0] k_lw_data;
  logic [63:0]  k_lw_mask;

  wc_store_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .part_mode_i(part_mode),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_be_i(st_be), .st_tid_i(st_tid),
    .flush_i(flush), .flush_done_o(done),
    .lw_valid_o(lw_valid), .lw_ready_i(lw_ready), .lw_addr_o(lw_addr),
    .lw_data_o(lw_data), .lw_mask_o(lw_mask));

  wc_store_buf #(.NUM_BUF(8), .KEEP_FREE(2)) dut_kf (
    .clk_i(clk), .rst_ni(rst_n), .part_mode_i(1'b0),
    .st_valid_i(k_st_valid), .st_ready_o(k_st_ready), .st_addr_i(k_st_addr),
    .st_data_i(k_st_data), .st_be_i(k_st_be), .st_tid_i(1'b0),
    .flush_i(k_flush), .flush_done_o(k_done),
    .lw_valid_o(k_lw_valid), .lw_ready_i(k_lw_ready), .lw_addr_o(k_lw_addr),
    .lw_data_o(k_lw_data), .lw_mask_o(k_lw_mask));

  typedef struct {
    logic [25:0]  la;
    logic [511:0] d;
    logic [63:0]  m;
    string        req;
  } exp_t;
  exp_t q_m[$];
  exp_t q_k[$];

  int checks = 0, fails = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [28:0] wa(input int line, input int w);
    return {26'(line), 3'(w)};
  endfunction
  function automatic logic [63:0] wv(input int line, input int w);
    return {16'(line), 16'(w), 32'hC0DE_0000 | 32'(line * 8 + w)};
  endfunction

  task automatic push_line(input bit k, input int line, input logic [511:0] d,
                           input logic [63:0] m, input string req);
    exp_t e;
    e.la = 26'(line); e.d = d; e.m = m; e.req = req;
    if (k) q_k.push_back(e); else q_m.push_back(e);
  endtask

  // expected line holding one fully written word
  task automatic push_word(input bit k, input int line, input int w, input string req);
    push_line(k, line, 512'(wv(line, w)) << (64 * w), 64'hFF << (8 * w), req);
  endtask

  task automatic compare(input bit k, input logic [25:0] a, input logic [511:0] d,
                         input logic [63:0] m);
    exp_t e;
    if ((k ? q_k.size() : q_m.size()) == 0) begin
      checks++; fails++;
      $display("FAIL R4 unexpected line write: actual=%h expected=none", a);
    end else begin
      e = k ? q_k.pop_front() : q_m.pop_front();
      check(a == e.la, e.req, "line address", 64'(a), 64'(e.la));
      checks++;
      if (d !== e.d) begin
        fails++;
        $display("FAIL %s line data: actual=%h expected=%h", e.req, d, e.d);
      end
      check(m == e.m, e.req, "byte mask", m, e.m);
    end
  endtask

  // monitor: a transfer happens at the rising edge after a negedge with valid&ready
  always @(negedge clk) begin
    if (rst_n && lw_valid && lw_ready)     compare(0, lw_addr, lw_data, lw_mask);
    if (rst_n && k_lw_valid && k_lw_ready) compare(1, k_lw_addr, k_lw_data, k_lw_mask);
  end

  task automatic st_put(input bit k, input logic [28:0] a, input logic [63:0] d,
                        input logic [7:0] be, input logic tid);
    @(posedge clk); #2;
    if (k) begin k_st_valid = 1; k_st_addr = a; k_st_data = d; k_st_be = be; end
    else begin st_valid = 1; st_addr = a; st_data = d; st_be = be; st_tid = tid; end
    do @(negedge clk); while (!(k ? k_st_ready : st_ready));
    @(posedge clk); #2;
    if (k) k_st_valid = 0; else st_valid = 0;
  endtask

  task automatic put_word(input bit k, input int line, input int w, input logic tid);
    st_put(k, wa(line, w), wv(line, w), 8'hFF, tid);
  endtask

  task automatic do_flush(input bit k);
    bit found;
    @(posedge clk); #2;
    if (k) k_flush = 1; else flush = 1;
    @(posedge clk); #2;
    if (k) k_flush = 0; else flush = 0;
    @(negedge clk);
    // R7 stores refused once the flush is seen
    check((k ? k_st_ready : st_ready) == 0, "R7", "ready during flush",
          64'(k ? k_st_ready : st_ready), 64'd0);
    found = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      if (k ? k_done : done) found = 1;
      else @(negedge clk);
    end
    check(found, "R7", "done pulse seen", 64'(found), 64'd1);
    check((k ? q_k.size() : q_m.size()) == 0, "R7", "lines pending at done",
          64'(k ? q_k.size() : q_m.size()), 64'd0);
    @(negedge clk);
    check((k ? k_done : done) == 0, "R7", "done lasts one cycle",
          64'(k ? k_done : done), 64'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [511:0] d;
    logic [63:0]  w0;

    // R1 reset state
    repeat (2) @(negedge clk);
    check(st_ready == 1, "R1", "ready in reset", 64'(st_ready), 64'd1);
    check(lw_valid == 0, "R1", "lw_valid in reset", 64'(lw_valid), 64'd0);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    check(done == 0, "R1", "done after reset", 64'(done), 64'd0);
    check(lw_valid == 0 && k_lw_valid == 0, "R1", "lw_valid after reset",
          64'(lw_valid), 64'd0);

    // R2 R3: overwrite then complete the line out of order
    w0 = wv(5, 0);
    w0[15:0] = 16'h2222;
    d = '0;
    for (int w = 1; w < 8; w++) d |= 512'(wv(5, w)) << (64 * w);
    d[63:0] = w0;
    push_line(0, 5, d, '1, "R3");
    put_word(0, 5, 0, 0);
    st_put(0, wa(5, 0), 64'h1111_1111_1111_2222, 8'h03, 0);
    for (int w = 7; w >= 1; w--) put_word(0, 5, w, 0);
    idle(5);
    check(q_m.size() == 0, "R3", "full line sent unprompted", 64'(q_m.size()), 64'd0);

    // R2 partial bytes, unwritten bytes zero
    d = '0;
    d[26*8 +: 8] = 8'hFF;
    d[28*8 +: 8] = 8'hFF;
    push_line(0, 6, d, (64'd1 << 26) | (64'd1 << 28), "R2");
    st_put(0, wa(6, 3), '1, 8'b0001_0100, 0);
    do_flush(0);

    // R7 drain in index order even after recency changes
    put_word(0, 20, 1, 0);
    put_word(0, 21, 1, 0);
    put_word(0, 22, 1, 0);
    put_word(0, 20, 2, 0);
    push_line(0, 20, (512'(wv(20, 1)) << 64) | (512'(wv(20, 2)) << 128),
              64'hFF << 8 | 64'hFF << 16, "R7");
    push_word(0, 21, 1, "R7");
    push_word(0, 22, 1, "R7");
    do_flush(0);

    // R8 shared pool holds ten lines from both threads
    for (int n = 30; n < 40; n++) put_word(0, n, 0, n[0]);
    idle(4);
    @(negedge clk);
    check(lw_valid == 0, "R8", "no eviction with ten lines", 64'(lw_valid), 64'd0);
    // R4 least recently used is evicted
    put_word(0, 30, 1, 1);
    push_word(0, 31, 0, "R4");
    put_word(0, 40, 0, 0);
    push_word(0, 32, 0, "R4");
    put_word(0, 41, 0, 1);
    idle(3);
    check(q_m.size() == 0, "R4", "victims sent", 64'(q_m.size()), 64'd0);
    push_line(0, 30, 512'(wv(30, 0)) | (512'(wv(30, 1)) << 64), 64'hFFFF, "R4");
    push_word(0, 40, 0, "R4");
    push_word(0, 41, 0, "R4");
    for (int n = 33; n < 40; n++) push_word(0, n, 0, "R4");
    do_flush(0);

    // R5 R6: stall while the output holds a line
    @(posedge clk); #2 lw_ready = 0;
    for (int n = 50; n < 60; n++) put_word(0, n, 0, 0);
    push_word(0, 50, 0, "R6");
    put_word(0, 60, 0, 0);
    idle(2);
    @(negedge clk);
    check(lw_valid == 1 && lw_addr == 26'd50, "R6", "line held", 64'(lw_addr), 64'd50);
    @(negedge clk);
    check(lw_valid == 1 && lw_addr == 26'd50, "R6", "line still held", 64'(lw_addr), 64'd50);
    push_word(0, 51, 0, "R5");
    @(posedge clk); #2;
    st_valid = 1; st_addr = wa(61, 0); st_data = wv(61, 0); st_be = 8'hFF; st_tid = 0;
    @(negedge clk);
    check(st_ready == 0, "R5", "stall on blocked eviction", 64'(st_ready), 64'd0);
    @(negedge clk);
    check(st_ready == 0, "R5", "stall persists", 64'(st_ready), 64'd0);
    @(posedge clk); #2 lw_ready = 1;
    @(negedge clk);
    check(st_ready == 1, "R5", "accepted when output frees", 64'(st_ready), 64'd1);
    @(posedge clk); #2 st_valid = 0;
    push_word(0, 60, 0, "R5");
    push_word(0, 61, 0, "R5");
    for (int n = 52; n < 60; n++) push_word(0, n, 0, "R5");
    do_flush(0);

    // R9 partitioned halves
    @(posedge clk); #2 part_mode = 1;
    for (int n = 70; n < 75; n++) put_word(0, n, 0, 0);
    push_word(0, 70, 0, "R9");
    put_word(0, 75, 0, 0);
    put_word(0, 80, 0, 1);
    idle(3);
    check(q_m.size() == 0, "R9", "half-pool eviction", 64'(q_m.size()), 64'd0);
    push_word(0, 75, 0, "R9");
    for (int n = 71; n < 75; n++) push_word(0, n, 0, "R9");
    push_word(0, 80, 0, "R9");
    do_flush(0);
    @(posedge clk); #2 part_mode = 0;

    // R10 spare buffers kept free
    for (int n = 90; n < 96; n++) put_word(1, n, 0, 0);
    idle(3);
    @(negedge clk);
    check(k_lw_valid == 0, "R10", "two free left, no early send", 64'(k_lw_valid), 64'd0);
    push_word(1, 90, 0, "R10");
    put_word(1, 96, 0, 0);
    idle(4);
    check(q_k.size() == 0, "R10", "early send of oldest", 64'(q_k.size()), 64'd0);
    for (int n = 91; n < 97; n++) push_word(1, n, 0, "R10");
    do_flush(1);

    idle(3);
    finish_run();
  end
endmodule